// File: doc/BRIEF.md
# Serial Peripheral Master with Multi-Select Mask

This block is a serial peripheral interface (SPI) master that is controlled through a small register port in the system clock domain. Writing a data word to the transmit register while the block is idle starts a transfer. The serial clock is not a separate clock. It is made by counting system clock cycles, and it runs in mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. Words go out most significant bit first. Each word that is shifted in is placed in a receive register, and status flags report it.

Each attached slave has one active-low select output. The number of outputs is fixed when the block is built. A writable mask chooses which outputs are driven low. Its value is captured when a transfer starts, so several slaves can be selected in one transfer. Software must make sure that only one selected slave drives MISO. The block does not check for contention on that line. An interrupt output combines the transmit-ready and receive-ready conditions, each gated by its own enable bit.

Register map, with 3-bit addresses:
- 0: transmit data (write).
- 1: receive data (read).
- 2: status (read; writing 1 to bit 2 clears it).
- 3: control (read/write).
- 4: select mask (read/write).

Top module: `spi_mask_master`

## Requirements
- R1: While busy, the serial clock has high and low phases of exactly HALF_DIV system clock cycles each. It is low whenever no transfer is in progress.
- R2: A transfer shifts DATA_W bits, one per serial clock edge pair. Bits leave on MOSI most significant first, with each bit held valid across the rising edge. MISO is sampled on each rising edge, most significant bit first, into the received word.
- R3: Outside a transfer every select output is high. During a transfer, select output k is low exactly when bit k of the mask is 1.
- R4: The mask is captured when the transfer starts. Writing the mask register during a transfer does not change the select outputs until a later transfer.
- R5: The select outputs go low HALF_DIV cycles before the first rising edge. They return high HALF_DIV cycles after the last falling edge, and they change only while the serial clock is low.
- R6: A write to address 0 while idle starts a transfer. A write to address 0 while busy is ignored and does not start a further transfer.
- R7: The status register reads bit 0 = transmit ready (idle), bit 1 = receive ready, and bit 2 = overrun. After reset it reads 3'b001.
- R8: Reading address 1 returns the last received word and clears receive ready.
- R9: If a word completes while receive ready is still set, overrun sets and the receive data is replaced. Writing status with bit 2 set clears overrun.
- R10: irq = (control bit 0 AND transmit ready) OR (control bit 1 AND receive ready).
- R11: MOSI does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive ready at address 1) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from the selected slave |
| ss_n | output | N_SLAVES | Active-low select, one per slave |

## Verification
The checker watches four serial-side rules on every cycle: the serial clock stays low when idle, MOSI holds while the clock is high, the selects change only while the clock is low, and all selects are high when idle. The bench then sweeps all 256 transmit values and all eight masks of a three-slave build. For each transfer it computes the shifted words, select patterns and lead/lag cycle counts, and compares them against what it observes. Several behaviours can only be shown by scenarios: a mask or transmit write landing mid-transfer being ignored, the overrun sequence, and the read-to-clear flag and interrupt gating.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LEAD,
        SH_BITS,
        SH_TAIL
    } sh_state_e;

    localparam logic [2:0] A_TXD  = 3'd0;
    localparam logic [2:0] A_RXD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_CTRL = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_mm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        sh_state_e         st;
        logic [DATA_W-1:0] sr;
        logic [BW-1:0]     cnt;
        logic              ck;
        logic              smp;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        unique case (s_q.st)
            SH_IDLE: if (start) begin
                s_d.st  = SH_LEAD;
                s_d.sr  = tx_word;
                s_d.cnt = '0;
                s_d.ck  = 1'b0;
            end
            SH_LEAD: if (tick) begin
                s_d.st  = SH_BITS;
                s_d.ck  = 1'b1;
                s_d.smp = miso;
            end
            SH_BITS: if (tick) begin
                if (s_q.ck) begin
                    s_d.ck = 1'b0;
                    s_d.sr = {s_q.sr[DATA_W-2:0], s_q.smp};
                    if (s_q.cnt == LAST_BIT) s_d.st  = SH_TAIL;
                    else                     s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    s_d.ck  = 1'b1;
                    s_d.smp = miso;
                end
            end
            SH_TAIL: if (tick) begin
                s_d.st = SH_IDLE;
                done   = 1'b1;
            end
            default: s_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SH_IDLE, sr: '0, cnt: '0, ck: 1'b0, smp: 1'b0};
        else        s_q <= s_d;
    end

    assign busy    = (s_q.st != SH_IDLE);
    assign sclk    = s_q.ck;
    assign mosi    = s_q.sr[DATA_W-1];
    assign rx_word = s_q.sr;
endmodule

// File: rtl/spi_mask_master.sv
module spi_mask_master
    import spi_mm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int N_SLAVES = 3,
    parameter int HALF_DIV = 2,
    parameter int REG_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [N_SLAVES-1:0] ss_n
);
    typedef struct packed {
        logic [DATA_W-1:0]   rx_data;
        logic                rx_full;
        logic                ovr;
        logic                ie_tx;
        logic                ie_rx;
        logic [N_SLAVES-1:0] mask;
        logic [N_SLAVES-1:0] sel;
    } rg_t;

    rg_t r_d, r_q;

    logic              xfer_busy;
    logic              tick;
    logic              done;
    logic              start;
    logic              rx_read;
    logic [DATA_W-1:0] rx_word;

    assign start   = reg_wr && (reg_addr == A_TXD) && !xfer_busy;
    assign rx_read = reg_rd && (reg_addr == A_RXD);

    spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (xfer_busy),
        .tick (tick)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_word(reg_wdata[DATA_W-1:0]),
        .tick   (tick),
        .miso   (miso),
        .busy   (xfer_busy),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (done),
        .rx_word(rx_word)
    );

    always_comb begin
        r_d = r_q;
        if (start) r_d.sel = r_q.mask;
        if (reg_wr) begin
            unique case (reg_addr)
                A_STAT: if (reg_wdata[2]) r_d.ovr = 1'b0;
                A_CTRL: begin
                    r_d.ie_tx = reg_wdata[0];
                    r_d.ie_rx = reg_wdata[1];
                end
                A_MASK: r_d.mask = reg_wdata[N_SLAVES-1:0];
                default: ;
            endcase
        end
        if (done) begin
            r_d.rx_data = rx_word;
            r_d.rx_full = 1'b1;
            if (r_q.rx_full && !rx_read) r_d.ovr = 1'b1;
        end else if (rx_read) begin
            r_d.rx_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_RXD:  reg_rdata = REG_W'(r_q.rx_data);
            A_STAT: reg_rdata = REG_W'({r_q.ovr, r_q.rx_full, !xfer_busy});
            A_CTRL: reg_rdata = REG_W'({r_q.ie_rx, r_q.ie_tx});
            A_MASK: reg_rdata = REG_W'(r_q.mask);
            default: reg_rdata = '0;
        endcase
    end

    assign ss_n = ~(r_q.sel & {N_SLAVES{xfer_busy}});
    assign irq  = (r_q.ie_tx && !xfer_busy) || (r_q.ie_rx && r_q.rx_full);
endmodule

// File: rtl/spi_mm_checks.sv
module spi_mm_checks #(
    parameter int N_SLAVES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                sclk,
    input logic                mosi,
    input logic [N_SLAVES-1:0] ss_n
);
    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R5
    sel_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ss_n) |-> (!sclk && !$past(sclk)));

    // R3
    sel_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ss_n));
endmodule

bind spi_mask_master spi_mm_checks #(.N_SLAVES(N_SLAVES)) u_checks (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (xfer_busy),
    .sclk (sclk),
    .mosi (mosi),
    .ss_n (ss_n)
);

// File: tb/tb_spi_mask_master.sv
module tb_spi_mask_master;
    localparam int DW = 8;
    localparam int NS = 3;
    localparam int HD = 2;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [2:0]    reg_addr = 3'd2;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          irq, sclk, mosi;
    logic          miso = 1'b0;
    logic [NS-1:0] ss_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_mask_master #(.DATA_W(DW), .N_SLAVES(NS), .HALF_DIV(HD), .REG_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd2;
        #1;
    endtask

    task automatic peek(input logic [2:0] a, output logic [RW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 3'd2;
    endtask

    task automatic read_rx(output logic [RW-1:0] d);
        reg_rd = 1'b1; reg_addr = 3'd1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 3'd2;
        #1;
    endtask

    task automatic xfer(input logic [DW-1:0] tx, input logic [DW-1:0] sw,
                        input logic [NS-1:0] mask, input bit disturb);
        logic [DW-1:0] cap = '0;
        int bidx = DW - 1;
        int t = 0;
        int rises = 0;
        int t_ss = -1, t_r1 = -1, t_f1 = -1, t_fl = -1, t_off = -1;
        int sel_bad = 0;
        logic prev = 1'b0;
        bit stuck = 1'b0;
        logic [NS-1:0] exp_ss = ~mask;
        wr(3'd4, RW'(mask));
        miso = sw[DW-1];
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = RW'(tx);
        @(negedge clk);
        forever begin
            if (disturb && t == 5) begin
                reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = RW'(mask ^ 3'b111);
            end else if (disturb && t == 6) begin
                reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = RW'(~tx);
            end else begin
                reg_wr = 1'b0; reg_addr = 3'd2;
            end
            #1;
            if (ss_n != '1 && t_ss < 0) t_ss = t;
            if (ss_n != '1 && ss_n != exp_ss) sel_bad++;
            if (sclk && !prev) begin
                rises++;
                cap = {cap[DW-2:0], mosi};
                if (t_r1 < 0) t_r1 = t;
            end
            if (!sclk && prev) begin
                if (t_f1 < 0) t_f1 = t;
                t_fl = t;
                if (bidx > 0) begin bidx--; miso = sw[bidx]; end
            end
            if (t_ss >= 0 && ss_n == '1 && t_off < 0) t_off = t;
            if (reg_addr == 3'd2 && reg_rdata[0]) break;
            if (t > 2000) begin stuck = 1'b1; break; end
            prev = sclk; t++;
            @(negedge clk);
        end
        reg_wr = 1'b0; reg_addr = 3'd2;
        check(!stuck, "R6 transfer finishes", t, 0);
        check(cap == tx, "R2 MOSI word", int'(cap), int'(tx));
        check(rises == DW, "R2 edge count", rises, DW);
        check(sel_bad == 0, "R3/R4 select pattern", sel_bad, 0);
        check(t_f1 - t_r1 == HD, "R1 high phase", t_f1 - t_r1, HD);
        check(t_r1 - (mask == '0 ? 0 : t_ss) == (mask == '0 ? HD : HD) || mask == '0,
              "R5 select lead", t_r1 - t_ss, HD);
        if (mask == '0) check(t_ss < 0, "R3 no select with empty mask", t_ss, -1);
        else            check(t_off - t_fl == HD, "R5 select lag", t_off - t_fl, HD);
        if (disturb) begin
            int moves = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk); #1;
                if (sclk || ss_n != '1 || !reg_rdata[0]) moves++;
            end
            check(moves == 0, "R6 busy write ignored", moves, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        peek(3'd2, d);
        check(d == 16'h0001, "R7 reset status", int'(d), 1);
        check(ss_n == '1 && !sclk && !irq, "R3 reset outputs",
              int'({ss_n, sclk, irq}), int'({3'b111, 2'b00}));

        // R2 R3 R4 R5 R8: sweep all words and masks
        for (int i = 0; i < 256; i++) begin
            logic [DW-1:0] sw = DW'((i * 37 + 11) & 255);
            xfer(DW'(i), sw, NS'(i % 8), (i % 16) == 5);
            peek(3'd2, d);
            check(d[1] == 1'b1, "R7 rx ready after word", int'(d[1]), 1);
            read_rx(d);
            check(d == RW'(sw), "R2 received word", int'(d), int'(sw));
            peek(3'd2, d);
            check(d == 16'h0001, "R8 read clears rx ready", int'(d), 1);
        end

        // R9 overrun
        xfer(8'hA5, 8'h3C, 3'b010, 1'b0);
        xfer(8'h5A, 8'hC3, 3'b100, 1'b0);
        peek(3'd2, d);
        check(d == 16'h0007, "R9 overrun set", int'(d), 7);
        read_rx(d);
        check(d == 16'h00C3, "R9 data replaced", int'(d), 16'hC3);
        peek(3'd2, d);
        check(d == 16'h0005, "R9 overrun holds after read", int'(d), 5);
        wr(3'd2, 16'h0004);
        peek(3'd2, d);
        check(d == 16'h0001, "R9 overrun cleared", int'(d), 1);

        // R10 interrupt gating
        check(!irq, "R10 irq off with no enables", int'(irq), 0);
        wr(3'd3, 16'h0001);
        check(irq, "R10 tx ready irq", int'(irq), 1);
        wr(3'd3, 16'h0002);
        check(!irq, "R10 rx irq with empty rx", int'(irq), 0);
        xfer(8'h11, 8'h80, 3'b001, 1'b0);
        check(irq, "R10 rx ready irq", int'(irq), 1);
        read_rx(d);
        check(!irq, "R10 irq drops after read", int'(irq), 0);
        wr(3'd3, 16'h0000);
        check(!irq, "R10 irq disabled", int'(irq), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule